// File: doc/BRIEF.md
# Fine-Adjust PWM D/A Generator

This block turns a 14-bit digital value into a pulse-width output that an external low-pass filter can smooth into an analog level. A free-running 14-bit counter advances on each resolution tick. Its low bits mark the position inside a short base cycle and its high bits number the base cycles inside a frame of 16384 ticks. The upper part of the value sets how many ticks the output stays high in every base cycle. The lower part sets how many base cycles in each frame get one extra tick of high time. Those extra ticks are spread evenly through the frame by comparing the frame index, read in bit-reversed order, with the fine field.

A 16-bit register holds the value, a carrier select and a fixed bit. Software may only access it as a whole word. A new value is written into a shadow copy, and the waveform logic takes it over only when the counter wraps. Each frame therefore uses one value throughout. If the value lies outside the valid range for the selected carrier, the output stays low.

Top module: `pwmda_fine_dac`

## Requirements
- R1: The register layout is: bits 15:2 hold the 14-bit value, bit 1 selects the carrier (0 = 64-tick base cycle, 1 = 256-tick base cycle), and bit 0 always reads 1 whatever is written to it.
- R2: After reset the register reads 0xFFFF and `pwm_out` is low.
- R3: A write with `wr_be` other than 2'b11 leaves the register unchanged.
- R4: With carrier 0 the base position is counter bits 5:0. The output is high while the position is below value[13:8] plus an extra of 1. The extra applies when counter bits 13:6, bit-reversed (bit 13 becomes the LSB), are below value[7:0].
- R5: With carrier 1 the base position is counter bits 7:0. The output is high while the position is below value[13:6] plus an extra of 1. The extra applies when counter bits 13:8, bit-reversed, are below value[5:0].
- R6: The valid register range is 0x0401 to 0xFFFD with carrier 0, and 0x0103 to 0xFFFF with carrier 1. Outside that range the output is held low.
- R7: While enabled, a written value is used only from the cycle in which the counter wraps from 0x3FFF to 0.
- R8: The counter advances by one only on clocks where `res_tick` is high. `pwm_out` is a register that each clock takes the level the counter and the value in use had before that edge.
- R9: While `enable` is low the counter is held at 0, `pwm_out` goes low on the next clock, and the value in use follows the register, so enabling starts a fresh frame with the latest value.
- R10: With value bits 1:0 clear, the extra-tick pattern does not depend on counter bits 13:12 (12-bit operation), and the waveform still follows R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables; only 2'b11 writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register read value |
| res_tick | input | 1 | Resolution tick enable for the counter |
| enable | input | 1 | Channel run enable |
| pwm_out | output | 1 | Registered PWM output |

## Verification
A wrong counter, a wrong bit reversal or a wrong frame-load point changes the high time of some base cycle. The bench compares the output against an independent model on every clock, so such a fault shows within one base cycle. Faults in the bit reversal or the fine comparison may appear only in certain base cycles, so each carrier is run for more than a full frame. A held-low fault on an invalid value shows within one base cycle of enabling, and a faulty byte-enable or fixed bit shows on `rd_data` the clock after the write.

// File: rtl/pwmda_pkg.sv
package pwmda_pkg;
  localparam int unsigned PD_CNT_W     = 14;
  localparam int unsigned PD_SHORT_LOG = 6;
  localparam int unsigned PD_LONG_LOG  = 8;

  typedef enum logic {
    CARRIER_SHORT = 1'b0,
    CARRIER_LONG  = 1'b1
  } carrier_e;
endpackage

// File: rtl/pwmda_regs.sv
module pwmda_regs #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned BE_W  = REG_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [BE_W-1:0]  wr_be,
  input  logic [REG_W-1:0] wr_data,
  input  logic             en,
  input  logic             load_frame,
  output logic [REG_W-1:0] shadow_o,
  output logic [REG_W-1:0] active_o
);
  logic full_word;
  logic unused_lsb;

  assign full_word  = wr_en && (&wr_be);
  assign unused_lsb = wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_o <= '1;
      active_o <= '1;
    end else begin
      if (full_word)
        shadow_o <= {wr_data[REG_W-1:1], 1'b1};
      if (!en || load_frame)
        active_o <= shadow_o;
    end
  end

  // R3: partial-width writes never touch the register
  p_word_only_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(&wr_be)) |=> $stable(shadow_o));

  // R1: fixed bit reads as one
  p_rsvd_one_r1: assert property (@(posedge clk) disable iff (rst)
    shadow_o[0]);

  // R7: value in use changes only at a frame wrap while running
  p_frame_load_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !load_frame) |=> $stable(active_o));
endmodule

// File: rtl/pwmda_counter.sv
module pwmda_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign wrap_o = en && tick && (cnt_o == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || !en)
      cnt_o <= '0;
    else if (tick)
      cnt_o <= cnt_o + 1'b1;
  end

  // R8: counter moves by one on a tick only
  p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
    (en && tick) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(cnt_o));
  // R9: disabled counter sits at zero
  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_o == '0));
endmodule

// File: rtl/pwmda_shaper.sv
module pwmda_shaper
  import pwmda_pkg::*;
#(
  parameter int unsigned CNT_W   = PD_CNT_W,
  parameter int unsigned SHORT_W = PD_SHORT_LOG,
  parameter int unsigned LONG_W  = PD_LONG_LOG,
  parameter int unsigned REG_W   = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [REG_W-1:0] active,
  output logic             pwm_o
);
  localparam int unsigned FS_W = CNT_W - SHORT_W;
  localparam int unsigned FL_W = CNT_W - LONG_W;
  // lowest legal word per carrier: coarse field of one, fine field zero
  localparam logic [REG_W-1:0] MIN_S = REG_W'((1 << (FS_W + 2)) | 1);
  localparam logic [REG_W-1:0] MIN_L = REG_W'((1 << (FL_W + 2)) | 3);

  logic [CNT_W-1:0] value;
  carrier_e         carrier;
  logic [FS_W-1:0]  rev_s;
  logic [FL_W-1:0]  rev_l;
  logic [SHORT_W:0] thr_s;
  logic [LONG_W:0]  thr_l;
  logic             hi_s, hi_l, in_range, pwm_d;

  assign value   = active[REG_W-1:2];
  assign carrier = carrier_e'(active[1]);

  // frame index read MSB-first so the extra ticks interleave
  for (genvar i = 0; i < FS_W; i++) begin : g_rev_s
    assign rev_s[i] = cnt[CNT_W-1-i];
  end
  for (genvar i = 0; i < FL_W; i++) begin : g_rev_l
    assign rev_l[i] = cnt[CNT_W-1-i];
  end

  always_comb begin
    thr_s = {1'b0, value[CNT_W-1:FS_W]} + (SHORT_W+1)'(rev_s < value[FS_W-1:0]);
    thr_l = {1'b0, value[CNT_W-1:FL_W]} + (LONG_W+1)'(rev_l < value[FL_W-1:0]);
    hi_s  = {1'b0, cnt[SHORT_W-1:0]} < thr_s;
    hi_l  = {1'b0, cnt[LONG_W-1:0]} < thr_l;
    // upper limits are the all-ones words, so only the floor matters
    in_range = (carrier == CARRIER_LONG) ? (active >= MIN_L) : (active >= MIN_S);
    pwm_d = en && in_range && ((carrier == CARRIER_LONG) ? hi_l : hi_s);
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= pwm_d;
  end

  // R6: an illegal word keeps the output low
  p_out_of_range_low_r6: assert property (@(posedge clk) disable iff (rst)
    (active < MIN_L) |=> !pwm_o);
  // R9: disabled channel drives low
  p_off_low_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_o);
  // R4: position past the longest possible short high time is low
  p_short_tail_r4: assert property (@(posedge clk) disable iff (rst)
    (carrier == CARRIER_SHORT && {1'b0, cnt[SHORT_W-1:0]} > {1'b0, value[CNT_W-1:FS_W]}) |=> !pwm_o);
endmodule

// File: rtl/pwmda_fine_dac.sv
module pwmda_fine_dac
  import pwmda_pkg::*;
#(
  parameter int unsigned CNT_W   = PD_CNT_W,
  parameter int unsigned SHORT_W = PD_SHORT_LOG,
  parameter int unsigned LONG_W  = PD_LONG_LOG
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_be,
  input  logic [15:0]  wr_data,
  output logic [15:0]  rd_data,
  input  logic         res_tick,
  input  logic         enable,
  output logic         pwm_out
);
  localparam int unsigned REG_W = CNT_W + 2;

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [REG_W-1:0] shadow, active;

  pwmda_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(enable), .tick(res_tick),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  pwmda_regs #(.REG_W(REG_W), .BE_W(2)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .en(enable), .load_frame(wrap), .shadow_o(shadow), .active_o(active)
  );

  pwmda_shaper #(.CNT_W(CNT_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W), .REG_W(REG_W)) u_shape (
    .clk(clk), .rst(rst), .en(enable), .cnt(cnt), .active(active), .pwm_o(pwm_out)
  );

  assign rd_data = shadow;

  // R2: reset leaves the register at all ones
  p_reset_word_r2: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == 16'hFFFF));
endmodule

// File: tb/sim_pwmda_fine_dac.sv
`timescale 1ns/1ps
module sim_pwmda_fine_dac;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] rd_data;
  logic        res_tick = 1'b1;
  logic        enable = 1'b0;
  logic        pwm_out;

  int    checks = 0;
  int    errors = 0;
  string tag = "R2";
  bit    done = 1'b0;

  logic [13:0] m_cnt;
  logic [15:0] m_sh, m_act;
  logic        qexp[$];

  always #2 clk = ~clk;

  pwmda_fine_dac u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .res_tick(res_tick), .enable(enable), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string t, input logic [15:0] a, input logic [15:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, a, e);
    end
  endtask

  // expected level from R4, R5, R6 for a counter value and register word
  function automatic logic exp_level(input logic [13:0] c, input logic [15:0] r);
    logic [7:0] rs;
    logic [5:0] rl;
    int coarse, fine, pos, extra;
    for (int i = 0; i < 8; i++) rs[i] = c[13-i];
    for (int i = 0; i < 6; i++) rl[i] = c[13-i];
    if (!r[1]) begin
      if (r < 16'h0401) return 1'b0;
      pos = int'(c[5:0]); coarse = int'(r[15:10]); fine = int'(r[9:2]);
      extra = (int'(rs) < fine) ? 1 : 0;
    end else begin
      if (r < 16'h0103) return 1'b0;
      pos = int'(c[7:0]); coarse = int'(r[15:8]); fine = int'(r[7:2]);
      extra = (int'(rl) < fine) ? 1 : 0;
    end
    return (pos < coarse + extra);
  endfunction

  // driver side: model pushes the level expected after each edge; monitor pops it
  always @(negedge clk) begin
    logic        e, got;
    logic [15:0] nsh;
    if (rst) begin
      m_cnt = '0; m_sh = 16'hFFFF; m_act = 16'hFFFF;
      qexp.delete();
    end else begin
      e = enable ? exp_level(m_cnt, m_act) : 1'b0;
      qexp.push_back(e);
      nsh = (wr_en && wr_be == 2'b11) ? {wr_data[15:1], 1'b1} : m_sh;
      if (!enable) begin
        m_cnt = '0; m_act = m_sh;
      end else if (res_tick) begin
        if (m_cnt == 14'h3FFF) m_act = m_sh;
        m_cnt = m_cnt + 1'b1;
      end
      m_sh = nsh;
      got = qexp.pop_front();
      check(pwm_out === got, tag, {15'd0, pwm_out}, {15'd0, got});
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic [1:0] be);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    cyc(1);
    wr_en = 1'b0; wr_be = 2'b00;
  endtask

  task automatic low_run(input logic [15:0] word, input string t);
    int hi;
    hi = 0;
    enable = 1'b0;
    wr(word, 2'b11);
    cyc(1);
    enable = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      cyc(1);
      if (pwm_out) hi++;
    end
    check(hi == 0, t, hi[15:0], 16'd0);
  endtask

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(2);
    // R2: reset state
    check(rd_data === 16'hFFFF, "R2 reset word", rd_data, 16'hFFFF);
    check(pwm_out === 1'b0, "R2 reset output", {15'd0, pwm_out}, 16'd0);

    // R1: fixed bit forced to one
    tag = "R1";
    wr(16'h0000, 2'b11);
    check(rd_data === 16'h0001, "R1 fixed bit", rd_data, 16'h0001);
    wr(16'h1234, 2'b11);
    check(rd_data === 16'h1235, "R1 full write", rd_data, 16'h1235);

    // R3: byte-wide writes ignored
    tag = "R3";
    wr(16'hABCD, 2'b01);
    check(rd_data === 16'h1235, "R3 low byte", rd_data, 16'h1235);
    wr(16'hABCD, 2'b10);
    check(rd_data === 16'h1235, "R3 high byte", rd_data, 16'h1235);

    // R4: carrier 0, coarse 10, fine 37
    tag = "R4";
    wr(16'h2894, 2'b11);
    check(rd_data === 16'h2895, "R4 word", rd_data, 16'h2895);
    enable = 1'b1;
    cyc(16500);

    // R5: carrier 1, coarse 100, fine 21
    tag = "R5";
    enable = 1'b0;
    wr(16'h6456, 2'b11);
    cyc(2);
    enable = 1'b1;
    cyc(16500);

    // R8: sparse ticks
    tag = "R8";
    for (int k = 0; k < 3000; k++) begin
      res_tick = (k % 3 == 0);
      cyc(1);
    end
    res_tick = 1'b1;

    // R7: mid-frame write waits for the wrap
    tag = "R7";
    wr(16'hFFFD, 2'b11);
    cyc(17000);

    // R9: disable and re-enable
    tag = "R9";
    enable = 1'b0;
    cyc(3);
    check(pwm_out === 1'b0, "R9 disabled low", {15'd0, pwm_out}, 16'd0);
    enable = 1'b1;
    cyc(300);

    // R6: below range for each carrier, then lowest legal word
    tag = "R6";
    low_run(16'h03FC, "R6 carrier0 below range");
    low_run(16'h00FE, "R6 carrier1 below range");
    enable = 1'b0;
    wr(16'h0103, 2'b11);
    cyc(1);
    enable = 1'b1;
    cyc(1200);

    // R10: 12-bit operation, coarse 5, fine 0x40
    tag = "R10";
    enable = 1'b0;
    wr(16'h1500, 2'b11);
    cyc(1);
    enable = 1'b1;
    cyc(16500);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule